// File: doc/BRIEF.md
# Configurable Registered Logic Cell

This block is one programmable logic cell. A single-bit logic value is taken from one of two sum inputs: a shared sum or a direct bypass sum. That value can be inverted by configuration and is then driven on a combinational output. The same value, or a bit taken straight from a pad, is loaded into a one-bit storage element. The storage element works as an edge-triggered D register, a transparent D latch or a toggle flip-flop. The stored bit drives a second output, so the cell gives a registered result and a separate combinational result at the same time.

Everything runs on one system clock `clk`. The cell's "clock" is a logic-level signal that the cell samples. Four global clocks, two shared term clocks and a per-cell term clock can be selected. An active edge is a rising transition of the selected level, after any inversion, between two consecutive system cycles. The clock enable, set and reset each come from selectable sources. Set and reset act on the registered output in the same cycle they are seen. Configuration inputs are expected to be static during operation.

Top module: `mc_cell`

## Requirements
- R1: While `rst` is high and in the first cycle after it, with no set or reset source active, `reg_q` is 0. After `rst` the selected clock counts as already high, so a clock that is high at release gives no edge.
- R2: The logic value is `bypass_sum` when `cfg_bypass`=1 and `shared_sum` when it is 0.
- R3: `comb_o` equals the logic value XOR `cfg_invert`, combinationally.
- R4: In mode 0 (`cfg_mode`=0, and 3, which behaves the same), on an active edge with enable true, the stored bit takes the data value. The data value is `pad_in` when `cfg_pad_load`=1, otherwise the inverted logic value. The stored bit is visible on `reg_q` in the next system cycle.
- R5: In mode 1 (latch), while the selected clock level is high and enable is true, `reg_q` follows the data value combinationally. Otherwise it holds the last value.
- R6: In mode 2 (toggle), on an active edge with enable true and data 1, the stored bit inverts. With data 0 it holds.
- R7: `cfg_clk_sel` values 0..3 pick `gclk[0..3]`, 4 and 5 pick `sh_clk[0]` and `sh_clk[1]`, 6 picks `pt_clk`, and 7 gives a constant low level (no edge ever).
- R8: `cfg_clk_inv` inverts the selected clock level for selections 1..6 and has no effect for selection 0 or 7.
- R9: The enable is 1 for `cfg_ce_sel`=0, `gce` for 1, `pt_ce` for 2, and `gce & pt_ce` for 3. Without enable the stored bit holds.
- R10: The reset source is active when any bit of `cfg_rst_mask` is set together with its source: bit0 `gsr`, bit1 `sh_pr[0]`, bit2 `sh_pr[1]`, bit3 `pt_rst`. The set source uses `cfg_set_mask` with the same bits, except that bit3 is `pt_set`. An active reset forces `reg_q` to 0 in the same cycle and an active set forces it to 1. Reset wins over set, and the forced value is kept as the stored bit.
- R11: With `cfg_pad_load`=1 the storage element is fed from `pad_in`, while `comb_o` still carries the logic value, independent of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| shared_sum | input | 1 | Shared sum-of-terms input |
| bypass_sum | input | 1 | Direct bypass sum input |
| pad_in | input | 1 | Direct pad data |
| gclk | input | 4 | Global clock levels |
| sh_clk | input | 2 | Shared term clock levels |
| pt_clk | input | 1 | Per-cell term clock level |
| gce | input | 1 | Global clock enable |
| pt_ce | input | 1 | Term clock enable |
| gsr | input | 1 | Global set/reset |
| sh_pr | input | 2 | Shared term set/reset lines |
| pt_rst | input | 1 | Per-cell term reset |
| pt_set | input | 1 | Per-cell term preset |
| cfg_bypass | input | 1 | Logic source select |
| cfg_invert | input | 1 | Logic inversion |
| cfg_mode | input | 2 | Storage mode |
| cfg_clk_sel | input | 3 | Clock source select |
| cfg_clk_inv | input | 1 | Clock inversion |
| cfg_ce_sel | input | 2 | Enable source select |
| cfg_pad_load | input | 1 | Load storage from pad |
| cfg_rst_mask | input | 4 | Reset source mask |
| cfg_set_mask | input | 4 | Set source mask |
| reg_q | output | 1 | Registered output |
| comb_o | output | 1 | Combinational output |

## Verification
A wrong stored bit or a wrong remembered clock level shows on `reg_q` in the system cycle after the active edge that should have loaded it. It stays visible until the next load, set or reset. In latch mode a wrong transparency condition shows in the same cycle, as `reg_q` fails to follow the data value. A wrong set or reset decode shows at once, because both force the output combinationally. The bench compares both outputs against a behavioural model in every cycle, so any such divergence is caught in the first cycle it reaches a port.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int NUM_GCLK   = 4;
    localparam int NUM_SHCLK  = 2;
    localparam int NUM_SHPR   = 2;
    localparam int SEL_W      = $clog2(NUM_GCLK + NUM_SHCLK + 2);
    localparam int MASK_W     = NUM_SHPR + 2;
    localparam logic [SEL_W-1:0] SEL_PT   = SEL_W'(NUM_GCLK + NUM_SHCLK);
    localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(NUM_GCLK + NUM_SHCLK + 1);

    typedef enum logic [1:0] {
        ST_DREG   = 2'd0,
        ST_LATCH  = 2'd1,
        ST_TOGGLE = 2'd2,
        ST_DREG2  = 2'd3
    } store_mode_e;

    typedef enum logic [1:0] {
        CE_ON   = 2'd0,
        CE_GLB  = 2'd1,
        CE_TERM = 2'd2,
        CE_BOTH = 2'd3
    } ce_sel_e;

    typedef struct packed {
        logic level;
        logic edge_hit;
    } clk_evt_t;

    typedef struct packed {
        logic en;
        logic clr;
        logic pre;
    } ctl_t;

    function automatic logic pick_ce(input ce_sel_e s, input logic g, input logic t);
        case (s)
            CE_ON:   return 1'b1;
            CE_GLB:  return g;
            CE_TERM: return t;
            default: return g & t;
        endcase
    endfunction

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel
    import mc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_GCLK-1:0]   gclk,
    input  logic [NUM_SHCLK-1:0]  sh_clk,
    input  logic                  pt_clk,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  inv,
    output clk_evt_t              evt
);
    localparam int NSRC = NUM_GCLK + NUM_SHCLK + 1;

    logic [NSRC-1:0] srcs;
    logic            raw;
    logic            lvl;
    logic            prev_lvl;

    assign srcs = {pt_clk, sh_clk, gclk};

    always_comb begin
        raw = 1'b0;
        if (sel < SEL_NONE) raw = srcs[sel];
    end

    // selection 0 is the master clock and is never inverted; none stays low
    assign lvl = (sel == '0 || sel == SEL_NONE) ? raw : (raw ^ inv);

    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= 1'b1;
        else     prev_lvl <= lvl;
    end

    assign evt.level    = lvl;
    assign evt.edge_hit = lvl & ~prev_lvl;

    // R7
    no_clk_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> !evt.edge_hit);

    // R8
    master_noinv_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (evt.level == gclk[0]));

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  ce_sel_e              ce_sel,
    input  logic                 gce,
    input  logic                 pt_ce,
    input  logic                 gsr,
    input  logic [NUM_SHPR-1:0]  sh_pr,
    input  logic                 pt_rst,
    input  logic                 pt_set,
    input  logic [MASK_W-1:0]    rst_mask,
    input  logic [MASK_W-1:0]    set_mask,
    output ctl_t                 ctl
);
    logic [MASK_W-1:0] rst_src;
    logic [MASK_W-1:0] set_src;

    assign rst_src = {pt_rst, sh_pr, gsr};
    assign set_src = {pt_set, sh_pr, gsr};

    assign ctl.en  = pick_ce(ce_sel, gce, pt_ce);
    assign ctl.clr = |(rst_src & rst_mask);
    assign ctl.pre = |(set_src & set_mask);

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  store_mode_e mode,
    input  clk_evt_t    evt,
    input  ctl_t        ctl,
    input  logic        d,
    output logic        q_out
);
    logic q_st;
    logic open_latch;

    assign open_latch = (mode == ST_LATCH) && evt.level && ctl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_st <= 1'b0;
        end else if (ctl.clr) begin
            q_st <= 1'b0;
        end else if (ctl.pre) begin
            q_st <= 1'b1;
        end else begin
            case (mode)
                ST_LATCH:  if (open_latch) q_st <= d;
                ST_TOGGLE: if (evt.edge_hit && ctl.en && d) q_st <= ~q_st;
                default:   if (evt.edge_hit && ctl.en) q_st <= d;
            endcase
        end
    end

    always_comb begin
        if (ctl.clr)         q_out = 1'b0;
        else if (ctl.pre)    q_out = 1'b1;
        else if (open_latch) q_out = d;
        else                 q_out = q_st;
    end

    // R10
    rst_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |-> !q_out);

    // R4
    dreg_load_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode == ST_DREG || mode == ST_DREG2) && !ctl.clr && !ctl.pre
         && evt.edge_hit && ctl.en) |=> (q_st == $past(d)));

    // R6
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_TOGGLE && !ctl.clr && !ctl.pre && evt.edge_hit
         && ctl.en && d) |=> (q_st != $past(q_st)));

    // R9
    hold_no_en_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !ctl.clr && !ctl.pre) |=> $stable(q_st));

endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shared_sum,
    input  logic                 bypass_sum,
    input  logic                 pad_in,
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic [NUM_SHCLK-1:0] sh_clk,
    input  logic                 pt_clk,
    input  logic                 gce,
    input  logic                 pt_ce,
    input  logic                 gsr,
    input  logic [NUM_SHPR-1:0]  sh_pr,
    input  logic                 pt_rst,
    input  logic                 pt_set,
    input  logic                 cfg_bypass,
    input  logic                 cfg_invert,
    input  logic [1:0]           cfg_mode,
    input  logic [SEL_W-1:0]     cfg_clk_sel,
    input  logic                 cfg_clk_inv,
    input  logic [1:0]           cfg_ce_sel,
    input  logic                 cfg_pad_load,
    input  logic [MASK_W-1:0]    cfg_rst_mask,
    input  logic [MASK_W-1:0]    cfg_set_mask,
    output logic                 reg_q,
    output logic                 comb_o
);
    logic     logic_v;
    logic     data_v;
    clk_evt_t evt;
    ctl_t     ctl;

    assign logic_v = (cfg_bypass ? bypass_sum : shared_sum) ^ cfg_invert;
    assign data_v  = cfg_pad_load ? pad_in : logic_v;
    assign comb_o  = logic_v;

    mc_clk_sel u_clk (
        .clk    (clk),
        .rst    (rst),
        .gclk   (gclk),
        .sh_clk (sh_clk),
        .pt_clk (pt_clk),
        .sel    (cfg_clk_sel),
        .inv    (cfg_clk_inv),
        .evt    (evt)
    );

    mc_ctrl u_ctl (
        .ce_sel   (ce_sel_e'(cfg_ce_sel)),
        .gce      (gce),
        .pt_ce    (pt_ce),
        .gsr      (gsr),
        .sh_pr    (sh_pr),
        .pt_rst   (pt_rst),
        .pt_set   (pt_set),
        .rst_mask (cfg_rst_mask),
        .set_mask (cfg_set_mask),
        .ctl      (ctl)
    );

    mc_store u_st (
        .clk   (clk),
        .rst   (rst),
        .mode  (store_mode_e'(cfg_mode)),
        .evt   (evt),
        .ctl   (ctl),
        .d     (data_v),
        .q_out (reg_q)
    );

    // R11
    pad_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_pad_load && !cfg_bypass) |-> (comb_o == (shared_sum ^ cfg_invert)));

endmodule

// File: tb/sim_mc_cell.sv
module sim_mc_cell;
    localparam time CLK_P = 10ns;

    logic clk = 1'b0;
    logic rst;
    logic shared_sum, bypass_sum, pad_in, pt_clk, gce, pt_ce, gsr, pt_rst, pt_set;
    logic [3:0] gclk;
    logic [1:0] sh_clk, sh_pr;
    logic cfg_bypass, cfg_invert, cfg_clk_inv, cfg_pad_load;
    logic [1:0] cfg_mode, cfg_ce_sel;
    logic [2:0] cfg_clk_sel;
    logic [3:0] cfg_rst_mask, cfg_set_mask;
    logic reg_q, comb_o;

    int compared = 0;
    int mismatched = 0;
    int mq = 0;
    int mprev = 1;

    always #(CLK_P/2) clk = ~clk;

    mc_cell u0 (.*);

    function automatic int model_level();
        int raw;
        case (cfg_clk_sel)
            3'd0, 3'd1, 3'd2, 3'd3: raw = gclk[cfg_clk_sel];
            3'd4: raw = sh_clk[0];
            3'd5: raw = sh_clk[1];
            3'd6: raw = pt_clk;
            default: return 0;
        endcase
        if (cfg_clk_sel != 0 && cfg_clk_inv) raw = 1 - raw;
        return raw;
    endfunction

    function automatic int model_en();
        if (cfg_ce_sel == 0) return 1;
        if (cfg_ce_sel == 1) return gce;
        if (cfg_ce_sel == 2) return pt_ce;
        return gce && pt_ce;
    endfunction

    function automatic int model_logic();
        int v = cfg_bypass ? bypass_sum : shared_sum;
        return cfg_invert ? 1 - v : v;
    endfunction

    function automatic int model_data();
        return cfg_pad_load ? int'(pad_in) : model_logic();
    endfunction

    function automatic int model_clr();
        return (cfg_rst_mask[0] && gsr) || (cfg_rst_mask[1] && sh_pr[0]) ||
               (cfg_rst_mask[2] && sh_pr[1]) || (cfg_rst_mask[3] && pt_rst);
    endfunction

    function automatic int model_pre();
        return (cfg_set_mask[0] && gsr) || (cfg_set_mask[1] && sh_pr[0]) ||
               (cfg_set_mask[2] && sh_pr[1]) || (cfg_set_mask[3] && pt_set);
    endfunction

    function automatic int model_q();
        if (model_clr()) return 0;
        if (model_pre()) return 1;
        if (cfg_mode == 1 && model_level() && model_en()) return model_data();
        return mq;
    endfunction

    task automatic compare(input string tag);
        int eq = model_q();
        int ec = model_logic();
        compared++;
        if (int'(reg_q) != eq || int'(comb_o) != ec) begin
            mismatched++;
            $display("FAIL %s: reg_q=%0d comb_o=%0d expected reg_q=%0d comb_o=%0d",
                     tag, reg_q, comb_o, eq, ec);
        end
    endtask

    task automatic advance();
        int lvl = model_level();
        int edg = lvl && !mprev;
        if (rst) begin
            mq = 0; mprev = 1;
        end else begin
            if (model_clr()) mq = 0;
            else if (model_pre()) mq = 1;
            else if (cfg_mode == 1) begin
                if (lvl && model_en()) mq = model_data();
            end else if (cfg_mode == 2) begin
                if (edg && model_en() && model_data()) mq = 1 - mq;
            end else if (edg && model_en()) mq = model_data();
            mprev = lvl;
        end
    endtask

    task automatic step(input string tag);
        #1;
        if (!rst) compare(tag);
        @(posedge clk);
        advance();
        @(negedge clk);
    endtask

    task automatic quiet();
        {shared_sum, bypass_sum, pad_in, pt_clk, gce, pt_ce, gsr, pt_rst, pt_set} = '0;
        gclk = '0; sh_clk = '0; sh_pr = '0;
    endtask

    task automatic cfg(input int mode, input int sel, input int inv, input int ce);
        cfg_mode = 2'(mode); cfg_clk_sel = 3'(sel); cfg_clk_inv = 1'(inv);
        cfg_ce_sel = 2'(ce);
    endtask

    initial begin
        #(CLK_P * 200000);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        quiet();
        {cfg_bypass, cfg_invert, cfg_pad_load} = '0;
        cfg_rst_mask = '0; cfg_set_mask = '0;
        cfg(0, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        step("R1"); step("R1");
        rst = 1'b0; mq = 0; mprev = 1;
        gclk[0] = 1'b1; shared_sum = 1'b1;
        step("R1"); step("R1");

        // R2 / R3: source select and inversion on comb_o
        for (int k = 0; k < 16; k++) begin
            {cfg_bypass, cfg_invert, shared_sum, bypass_sum} = 4'(k);
            step(k < 8 ? "R2" : "R3");
        end

        // R4: D register with global clock 0
        cfg_bypass = 0; cfg_invert = 0; cfg(0, 0, 0, 0);
        gclk[0] = 0; step("R4");
        shared_sum = 1; gclk[0] = 1; step("R4"); step("R4");
        shared_sum = 0; step("R4"); gclk[0] = 0; step("R4");
        gclk[0] = 1; step("R4"); step("R4");

        // R8: inversion ignored on master clock, applied on clock 1
        cfg(0, 0, 1, 0); gclk = 4'b0000; shared_sum = 1; step("R8");
        gclk[0] = 1; step("R8"); step("R8");
        cfg(0, 1, 1, 0); gclk = 4'b0010; shared_sum = 0; step("R8");
        gclk[1] = 0; step("R8"); step("R8");

        // R7: each clock source, plus none
        for (int s = 0; s < 8; s++) begin
            cfg(0, s, 0, 0); quiet(); shared_sum = 1'(s & 1) ^ 1'b1;
            step("R7");
            gclk = 4'hF; sh_clk = 2'b11; pt_clk = 1; step("R7"); step("R7");
        end

        // R5: latch transparency
        quiet(); cfg(1, 6, 0, 0);
        shared_sum = 1; step("R5"); pt_clk = 1; step("R5");
        shared_sum = 0; step("R5"); pt_clk = 0; shared_sum = 1; step("R5"); step("R5");

        // R6: toggle
        cfg(2, 4, 0, 0); quiet(); shared_sum = 1;
        for (int t = 0; t < 8; t++) begin
            sh_clk[0] = ~sh_clk[0]; if (t == 5) shared_sum = 0; step("R6");
        end

        // R9: enable sources
        for (int c = 0; c < 4; c++) begin
            cfg(0, 0, 0, c); quiet(); step("R9");
            {gce, pt_ce} = 2'(c); shared_sum = ~reg_q; gclk[0] = 1; step("R9"); step("R9");
        end

        // R10: set/reset masks and priority
        cfg(0, 7, 0, 0); quiet(); cfg_rst_mask = 4'b1001; cfg_set_mask = 4'b0111;
        sh_pr[0] = 1; step("R10"); step("R10"); pt_rst = 1; step("R10");
        pt_rst = 0; gsr = 1; step("R10"); gsr = 0; sh_pr = 0; step("R10");
        pt_set = 1; step("R10"); cfg_set_mask = 4'b1000; step("R10");
        pt_set = 0; step("R10");
        cfg_rst_mask = 0; cfg_set_mask = 0;

        // R11: pad feeds storage, comb_o stays on logic
        cfg(0, 0, 0, 0); cfg_pad_load = 1; quiet();
        pad_in = 1; shared_sum = 0; step("R11"); gclk[0] = 1; step("R11"); step("R11");
        pad_in = 0; shared_sum = 1; gclk[0] = 0; step("R11"); gclk[0] = 1; step("R11"); step("R11");
        cfg_pad_load = 0;

        // mixed patterns across every mode
        for (int n = 0; n < 3000; n++) begin
            if (n % 24 == 0) begin
                cfg($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 1),
                    $urandom_range(0, 3));
                {cfg_bypass, cfg_invert, cfg_pad_load} = 3'($urandom);
                cfg_rst_mask = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
                cfg_set_mask = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            end
            {shared_sum, bypass_sum, pad_in, pt_clk, gce, pt_ce} = 6'($urandom);
            gclk = 4'($urandom); sh_clk = 2'($urandom);
            {gsr, sh_pr, pt_rst, pt_set} = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'h0;
            case (cfg_mode)
                2'd1:    step("R5");
                2'd2:    step("R6");
                default: step("R4");
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule